// File: doc/BRIEF.md
# 100 Mb/s Receive Symbol Stream Monitor

This block sits behind the symbol aligner of a 100 Mb/s twisted-pair receiver. It takes one already aligned and decoded 5-bit code group per clock. It finds the two-symbol start and end delimiters that bracket each frame and turns every data code group into a 4-bit nibble. It drives nibble data, data valid, receive error and carrier sense toward a MAC-side interface of the MII kind. All of these outputs are registered and follow the input symbol by one clock.

The block also watches for two line faults. The first is activity that does not open with a proper start delimiter, known as false carrier. The second is a frame cut short by a run of idles, known as premature end. Each fault sets a sticky status flag. Management logic reads the flags and clears them with a one-cycle read strobe.

Top module: `rx_stream_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it, nibble data, data valid, receive error, carrier sense and both status flags are all low.
- R2: While no frame is in progress, idle code groups (11111) keep carrier sense, data valid and receive error low. The start delimiter is J (11000) followed by K (10001). J raises carrier sense with data valid low, K keeps the same output, and data valid is only ever high while carrier sense is high.
- R3: Inside a frame each data code group produces data valid high, receive error low and its nibble, one clock after the symbol. The mapping from nibble 0 to F is 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: The end delimiter is T (01101) followed by R (00111). T gives carrier sense high with data valid low. R gives all outputs low, and the stream returns to the idle state.
- R5: A code group inside a frame that is not a data code and not a delimiter (for example 00000) gives data valid high, receive error high and nibble 0. The frame then continues.
- R6: Two consecutive idles inside a frame form a premature end. The first idle gives data valid and receive error high. The second gives data valid low, receive error high and carrier sense low, and it sets the premature-end flag.
- R7: False carrier occurs when a non-idle code other than J arrives between frames, or when J is followed by anything other than K. For that symbol the outputs are receive error high, data valid low, carrier sense high and nibble 1110, and the false-carrier flag is set. That output holds until two consecutive idles arrive; the second idle returns all outputs to low.
- R8: Both status flags rise one clock after their event and stay high until a read strobe. The two flags are independent, so an event of one kind leaves the other flag unchanged.
- R9: A read strobe clears both flags one clock later. If an event arrives in the same cycle as the strobe, the flag for that event stays high.
- R10: A T that is not followed by R gives data valid and receive error high with nibble 0 on the following symbol. The frame then continues, and a later T followed by R ends it normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 5 | Aligned, decoded 5-bit code group |
| stat_rd_i | input | 1 | Status read strobe, clears flags |
| rxd_o | output | 4 | Received nibble |
| rx_dv_o | output | 1 | Nibble data valid |
| rx_er_o | output | 1 | Receive error |
| crs_o | output | 1 | Carrier sense |
| stat_fc_o | output | 1 | Sticky false-carrier flag |
| stat_pe_o | output | 1 | Sticky premature-end flag |

## Verification
A status read and a new fault can land on the same clock edge, and the sticky flags must let the fault win. The bench drives the read strobe in the same cycle as the symbol that completes a false-carrier event. It judges the case by the flag still being high afterwards. A later plain read then clears the flag, and the bench checks that the other flag was not disturbed.

// File: rtl/rx_mon_pkg.sv
package rx_mon_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SSD_K, ST_DATA, ST_IDLE1, ST_ESD_R, ST_FALSE
   } mon_state_t;

   typedef enum logic [2:0] {
      K_DATA, K_IDLE, K_J, K_K, K_T, K_R, K_BAD
   } sym_kind_t;

   localparam logic [4:0] C_IDLE = 5'b11111;
   localparam logic [4:0] C_J    = 5'b11000;
   localparam logic [4:0] C_K    = 5'b10001;
   localparam logic [4:0] C_T    = 5'b01101;
   localparam logic [4:0] C_R    = 5'b00111;

   // returns {valid, nibble}
   function automatic logic [4:0] dec4b5b(input logic [4:0] s);
      logic [4:0] r;
      case (s)
         5'b11110: r = 5'h10;
         5'b01001: r = 5'h11;
         5'b10100: r = 5'h12;
         5'b10101: r = 5'h13;
         5'b01010: r = 5'h14;
         5'b01011: r = 5'h15;
         5'b01110: r = 5'h16;
         5'b01111: r = 5'h17;
         5'b10010: r = 5'h18;
         5'b10011: r = 5'h19;
         5'b10110: r = 5'h1A;
         5'b10111: r = 5'h1B;
         5'b11010: r = 5'h1C;
         5'b11011: r = 5'h1D;
         5'b11100: r = 5'h1E;
         5'b11101: r = 5'h1F;
         default:  r = 5'h00;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rx_sym_classify.sv
module rx_sym_classify
   import rx_mon_pkg::*;
#(
   parameter int SYM_W = 5,
   parameter int NIB_W = 4
) (
   input  logic [SYM_W-1:0]   sym_i,
   output sym_kind_t          kind_o,
   output logic [NIB_W-1:0]   nib_o
);
   logic [4:0] dec;

   always_comb begin
      dec   = dec4b5b(sym_i);
      nib_o = dec[NIB_W-1:0];
      if (sym_i == C_IDLE)    kind_o = K_IDLE;
      else if (sym_i == C_J)  kind_o = K_J;
      else if (sym_i == C_K)  kind_o = K_K;
      else if (sym_i == C_T)  kind_o = K_T;
      else if (sym_i == C_R)  kind_o = K_R;
      else if (dec[4])        kind_o = K_DATA;
      else                    kind_o = K_BAD;
   end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import rx_mon_pkg::*;
#(
   parameter int               NIB_W    = 4,
   parameter logic [NIB_W-1:0] FC_CODE  = 4'hE,
   parameter int               IDLE_RUN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sym_kind_t         kind_i,
   input  logic [NIB_W-1:0]  nib_i,
   output logic [NIB_W-1:0]  rxd_o,
   output logic              rx_dv_o,
   output logic              rx_er_o,
   output logic              crs_o,
   output logic              fc_set_o,
   output logic              pe_set_o
);
   localparam int CW = $clog2(IDLE_RUN + 1);

   if (IDLE_RUN < 1) begin : g_bad_run
      $error("IDLE_RUN must be at least 1");
   end

   mon_state_t       st, nxt;
   logic [CW-1:0]    cnt, n_cnt;
   logic [NIB_W-1:0] n_d;
   logic             n_dv, n_er, n_crs;

   always_comb begin
      nxt = st; n_cnt = cnt;
      n_d = '0; n_dv = 1'b0; n_er = 1'b0; n_crs = 1'b0;
      fc_set_o = 1'b0; pe_set_o = 1'b0;
      case (st)
         ST_IDLE: begin
            if (kind_i == K_J) begin
               nxt = ST_SSD_K; n_crs = 1'b1;
            end else if (kind_i != K_IDLE) begin
               nxt = ST_FALSE; fc_set_o = 1'b1; n_cnt = '0;
               n_crs = 1'b1; n_er = 1'b1; n_d = FC_CODE;
            end
         end
         ST_SSD_K: begin
            if (kind_i == K_K) begin
               nxt = ST_DATA; n_crs = 1'b1;
            end else begin
               nxt = ST_FALSE; fc_set_o = 1'b1; n_cnt = '0;
               n_crs = 1'b1; n_er = 1'b1; n_d = FC_CODE;
            end
         end
         ST_DATA, ST_IDLE1, ST_ESD_R: begin
            n_crs = 1'b1; n_dv = 1'b1;
            if (st == ST_ESD_R && kind_i == K_R) begin
               nxt = ST_IDLE; n_crs = 1'b0; n_dv = 1'b0;
            end else if (st == ST_ESD_R) begin
               nxt = ST_DATA; n_er = 1'b1;
            end else if (kind_i == K_DATA) begin
               nxt = ST_DATA; n_d = nib_i;
            end else if (kind_i == K_T) begin
               nxt = ST_ESD_R; n_dv = 1'b0;
            end else if (kind_i == K_IDLE && st == ST_IDLE1) begin
               nxt = ST_IDLE; pe_set_o = 1'b1;
               n_crs = 1'b0; n_dv = 1'b0; n_er = 1'b1;
            end else if (kind_i == K_IDLE) begin
               nxt = ST_IDLE1; n_er = 1'b1;
            end else begin
               nxt = ST_DATA; n_er = 1'b1;
            end
         end
         ST_FALSE: begin
            n_crs = 1'b1; n_er = 1'b1; n_d = FC_CODE;
            if (kind_i != K_IDLE) begin
               n_cnt = '0;
            end else if (cnt == CW'(IDLE_RUN - 1)) begin
               nxt = ST_IDLE; n_cnt = '0;
               n_crs = 1'b0; n_er = 1'b0; n_d = '0;
            end else begin
               n_cnt = cnt + 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; cnt <= '0;
         rxd_o <= '0; rx_dv_o <= 1'b0; rx_er_o <= 1'b0; crs_o <= 1'b0;
      end else begin
         st <= nxt; cnt <= n_cnt;
         rxd_o <= n_d; rx_dv_o <= n_dv; rx_er_o <= n_er; crs_o <= n_crs;
      end
   end

   assert_dv_needs_crs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dv_o |-> crs_o);
   assert_pe_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pe_set_o |=> (!rx_dv_o && rx_er_o && !crs_o));
   assert_fc_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fc_set_o |=> (rx_er_o && !rx_dv_o && crs_o && rxd_o == FC_CODE));
   assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(fc_set_o && pe_set_o));
endmodule

// File: rtl/rx_stat_latch.sv
module rx_stat_latch #(
   parameter int N        = 2,
   parameter bit SET_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_i,
   input  logic          rd_i,
   output logic [N-1:0]  flag_o
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      if (SET_WINS) begin : g_set_pri
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_o[i] <= 1'b0;
            else        flag_o[i] <= set_i[i] | (flag_o[i] & ~rd_i);
         end
         assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
      end else begin : g_rd_pri
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    flag_o[i] <= 1'b0;
            else if (rd_i) flag_o[i] <= 1'b0;
            else           flag_o[i] <= flag_o[i] | set_i[i];
         end
      end
      assert_flag_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_i && !set_i[i]) |=> !flag_o[i]);
   end
endmodule

// File: rtl/rx_stream_mon.sv
module rx_stream_mon
   import rx_mon_pkg::*;
#(
   parameter int               SYM_W    = 5,
   parameter int               NIB_W    = 4,
   parameter logic [NIB_W-1:0] FC_CODE  = 4'hE,
   parameter int               IDLE_RUN = 2,
   parameter bit               SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SYM_W-1:0]  sym_i,
   input  logic              stat_rd_i,
   output logic [NIB_W-1:0]  rxd_o,
   output logic              rx_dv_o,
   output logic              rx_er_o,
   output logic              crs_o,
   output logic              stat_fc_o,
   output logic              stat_pe_o
);
   localparam int NFLAG = 2;

   if (SYM_W != 5 || NIB_W != 4) begin : g_bad_width
      $error("code group must be 5 bits and nibble 4 bits");
   end

   sym_kind_t        kind;
   logic [NIB_W-1:0] nib;
   logic             fc_set, pe_set;
   logic [NFLAG-1:0] flags;

   rx_sym_classify #(.SYM_W(SYM_W), .NIB_W(NIB_W)) u_cls (
      .sym_i(sym_i), .kind_o(kind), .nib_o(nib));

   rx_frame_fsm #(.NIB_W(NIB_W), .FC_CODE(FC_CODE), .IDLE_RUN(IDLE_RUN)) u_fsm (
      .clk(clk), .rst_n(rst_n), .kind_i(kind), .nib_i(nib),
      .rxd_o(rxd_o), .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o), .crs_o(crs_o),
      .fc_set_o(fc_set), .pe_set_o(pe_set));

   rx_stat_latch #(.N(NFLAG), .SET_WINS(SET_WINS)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_i({pe_set, fc_set}), .rd_i(stat_rd_i),
      .flag_o(flags));

   assign stat_fc_o = flags[0];
   assign stat_pe_o = flags[1];
endmodule

// File: tb/rx_stream_mon_bench.sv
module rx_stream_mon_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] S_I = 5'b11111, S_J = 5'b11000, S_K = 5'b10001,
                          S_T = 5'b01101, S_R = 5'b00111, S_BAD = 5'b00000;

   logic       clk = 1'b0, rst_n = 1'b0, rd = 1'b0;
   logic [4:0] sym = S_I;
   logic [3:0] rxd;
   logic       dv, er, crs, fc, pe;
   int checks = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_stream_mon u_rx_stream_mon (
      .clk(clk), .rst_n(rst_n), .sym_i(sym), .stat_rd_i(rd),
      .rxd_o(rxd), .rx_dv_o(dv), .rx_er_o(er), .crs_o(crs),
      .stat_fc_o(fc), .stat_pe_o(pe));

   function automatic logic [4:0] enc(input logic [3:0] n);
      logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
      return t[n];
   endfunction

   task automatic check(input string req, input logic [6:0] exp);
      logic [6:0] act;
      act = {crs, dv, er, rxd};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s {crs,dv,er,rxd} act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic check_flags(input string req, input logic [1:0] exp);
      checks++;
      if ({fc, pe} !== exp) begin
         fails++;
         $display("FAIL %s {fc,pe} act=%b exp=%b", req, {fc, pe}, exp);
      end
   endtask

   // drive at a falling edge, return at the next one
   task automatic step(input logic [4:0] s, input logic r = 1'b0);
      sym = s; rd = r;
      @(negedge clk);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check("R1 in reset", 7'b0);
      check_flags("R1 in reset", 2'b00);
      rst_n = 1'b1;
      step(S_I);
      check("R1 after reset", 7'b0);
   endtask

   task automatic t_frame;
      step(S_I); check("R2 idle", 7'b0);
      step(S_J); check("R2 J", 7'b100_0000);
      step(S_K); check("R2 K", 7'b100_0000);
      for (int n = 0; n < 16; n++) begin
         step(enc(4'(n)));
         check("R3 data", {3'b110, 4'(n)});
      end
      step(S_T); check("R4 T", 7'b100_0000);
      step(S_R); check("R4 R", 7'b0);
      step(S_I); check("R4 back to idle", 7'b0);
      check_flags("R4 no flags", 2'b00);
   endtask

   task automatic t_invalid;
      step(S_J); step(S_K);
      step(enc(4'h5)); check("R5 pre", 7'b110_0101);
      step(S_BAD);     check("R5 bad code", 7'b111_0000);
      step(enc(4'hA)); check("R5 continues", 7'b110_1010);
      step(S_T); step(S_R); check("R5 end", 7'b0);
   endtask

   task automatic t_esd_broken;
      step(S_J); step(S_K);
      step(S_T);       check("R10 T", 7'b100_0000);
      step(enc(4'h3)); check("R10 T not R", 7'b111_0000);
      step(enc(4'h9)); check("R10 continues", 7'b110_1001);
      step(S_T); step(S_R); check("R10 end", 7'b0);
   endtask

   task automatic t_premature;
      step(S_J); step(S_K); step(enc(4'h7));
      step(S_I); check("R6 first idle", 7'b111_0000);
      check_flags("R6 not yet", 2'b00);
      step(S_I); check("R6 second idle", 7'b001_0000);
      check_flags("R6 flag set", 2'b01);
      step(S_I); check("R6 quiet", 7'b0);
      step(S_I); check_flags("R8 pe sticky", 2'b01);
   endtask

   task automatic t_false_carrier;
      step(enc(4'h3)); check("R7 non-J", 7'b101_1110);
      check_flags("R8 fc set pe kept", 2'b11);
      step(S_I); check("R7 one idle", 7'b101_1110);
      step(S_BAD); check("R7 still false", 7'b101_1110);
      step(S_I); check("R7 idle again", 7'b101_1110);
      step(S_I); check("R7 exit", 7'b0);
      step(S_I, 1'b1); check_flags("R9 read clears", 2'b00);
      step(S_J); check("R7 J", 7'b100_0000);
      step(enc(4'h0)); check("R7 J then data", 7'b101_1110);
      check_flags("R7 fc via J", 2'b10);
      step(S_I); step(S_I); check("R7 exit2", 7'b0);
   endtask

   task automatic t_read_collision;
      step(S_I, 1'b1); check_flags("R9 cleared", 2'b00);
      step(S_J); step(S_K); step(enc(4'h1)); step(S_I);
      step(S_I); check_flags("R9 pe before", 2'b01);
      step(S_R, 1'b1); check("R9 fc with read", 7'b101_1110);
      check_flags("R9 event beats read", 2'b10);
      step(S_I); step(S_I); check_flags("R8 fc sticky", 2'b10);
      step(S_I, 1'b1); check_flags("R9 final clear", 2'b00);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_frame();
      t_invalid();
      t_esd_broken();
      t_premature();
      t_false_carrier();
      t_read_collision();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule